// File: doc/BRIEF.md
# Clock Multiplier Control Sequencer

This block controls a frequency multiplier through a byte-wide register. Software must follow a fixed order. It writes the enable bit and waits a minimum enable interval. It then requests initialisation, and it polls a ready flag that rises once a modelled lock time has passed. An initialise request made too early, or while the selected oscillator is not reported valid, is refused and leaves a sticky error flag.

The analog loop is modelled digitally, and the block's clock is the fast reference. Each rising-edge strobe of the selected oscillator produces a burst of two or four base pulses on consecutive fast cycles. This burst reproduces the pulse pattern the multiplier gives for slow inputs. A 2/N scaler then thins those base pulses into the output clock-enable strobe. It passes exactly two pulses in every N base pulses, spread evenly. A factor-of-one setting passes every base pulse.

Top module: `clkmul_seq`

## Requirements
- R1: After reset, and after any write of 0x00 to the control register (addr 0), both registers read 0: enable, initialise, fields, ready and error are all cleared.
- R2: Control register layout: bit 7 enable, bit 6 initialise (reads 1 only once a request was accepted), bits 5:4 source, bit 3 reads 0, bits 2:0 scale code. The status register (addr 1) reads bit 0 ready and bit 1 error, with other bits 0.
- R3: An initialise request (a write with bits 7 and 6 set) is accepted only when enable was already set and at least ENA_WAIT clock cycles lie between the enabling write and the request.
- R4: Source code 00 (internal ×2) needs int_ok. Codes 01 (external ×2) and 10 (external ×4) need ext_ok. Code 11 is never accepted.
- R5: A refused initialise request sets the error bit, and the error bit stays set until a 0x00 write.
- R6: Ready rises exactly LOCK_CYCLES clock cycles after the edge that accepted the initialise request. Ready implies that initialise and enable are set.
- R7: Writing a different source or scale code while enabled drops ready at once. Ready returns only through an accepted initialise request, which restarts the lock time.
- R8: A write with bit 7 clear disables the block, drops initialise and ready, and restarts the enable interval. A write with bit 7 set and bit 6 clear drops initialise and ready.
- R9: Each int_edge strobe (source 00) or ext_edge strobe (01, 10) gives 2 base pulses, or 4 for source 10, on consecutive cycles. A strobe of the unselected oscillator gives none.
- R10: Scale codes 1..5 select N = code+2 (2/3 .. 2/7), and clk_en pulses exactly twice per N base pulses. Codes 0, 6 and 7 pass every base pulse.
- R11: clk_en is never high while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| int_ok | input | 1 | Internal oscillator valid |
| ext_ok | input | 1 | External oscillator valid and stable |
| int_edge | input | 1 | One-cycle strobe per internal oscillator rising edge |
| ext_edge | input | 1 | One-cycle strobe per external oscillator rising edge |
| clk_en | output | 1 | Output clock-enable strobe |

## Verification
The assertions assume that oscillator edge strobes come far enough apart that pending base pulses never pile up past the burst counter's range. The stimulus sends one strobe and then leaves at least five idle cycles, so no more than four pulses are ever pending. They also assume that writes are single-cycle strobes driven between clock edges. Every bench write lasts exactly one cycle, and every scaler run uses a whole number of N-pulse periods, so the expected strobe count is exact.

// File: rtl/clkmul_seq.sv
module clkmul_seq #(
  parameter int ENA_WAIT    = 20,
  parameter int LOCK_CYCLES = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       int_ok,
  input  logic       ext_ok,
  input  logic       int_edge,
  input  logic       ext_edge,
  output logic       clk_en
);
  localparam int WW = $clog2(ENA_WAIT + 1);
  localparam int LW = $clog2(LOCK_CYCLES + 1);

  logic          en_q, init_q, ready_q, err_q;
  logic [1:0]    src_q;
  logic [2:0]    scale_q;
  logic [WW-1:0] wait_cnt;
  logic [LW-1:0] lock_cnt;
  logic [3:0]    burst_cnt;
  logic [2:0]    acc;

  wire       wr_ctl   = wr_en & ~addr;
  wire       zero_wr  = wr_ctl & (wr_data == 8'h00);
  wire [1:0] n_src    = wr_data[5:4];
  wire [2:0] n_scale  = wr_data[2:0];
  wire       fld_chg  = (n_src != src_q) | (n_scale != scale_q);
  wire       wait_done = (wait_cnt == WW'(ENA_WAIT));

  logic src_ok;
  always_comb begin
    case (n_src)
      2'b00:        src_ok = int_ok;
      2'b01, 2'b10: src_ok = ext_ok;
      default:      src_ok = 1'b0;
    endcase
  end

  wire init_req  = wr_ctl & wr_data[7] & wr_data[6] & (~init_q | fld_chg);
  wire init_good = init_req & en_q & wait_done & src_ok;
  wire init_bad  = init_req & ~init_good;
  wire keep_run  = wr_data[7] & wr_data[6] & init_q & ~fld_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      src_q   <= 2'b00;
      scale_q <= 3'b000;
    end else if (wr_ctl) begin
      en_q    <= wr_data[7];
      src_q   <= n_src;
      scale_q <= n_scale;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wait_cnt <= '0;
    else if (!en_q || (wr_ctl && !wr_data[7]))
      wait_cnt <= '0;
    else if (!wait_done)
      wait_cnt <= wait_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      init_q <= 1'b0;
    else if (wr_ctl)
      init_q <= init_good | keep_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      lock_cnt <= '0;
    end else if (wr_ctl && !keep_run) begin
      ready_q  <= 1'b0;
      lock_cnt <= '0;
    end else if (init_q && !ready_q) begin
      if (lock_cnt == LW'(LOCK_CYCLES - 1)) ready_q <= 1'b1;
      else lock_cnt <= lock_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (zero_wr)  err_q <= 1'b0;
    else if (init_bad) err_q <= 1'b1;
  end

  wire       base_tick = (burst_cnt != 4'd0);
  wire       sel_edge  = (src_q == 2'b00) ? int_edge : ext_edge;
  wire [4:0] mult      = (src_q == 2'b10) ? 5'd4 : 5'd2;
  wire [4:0] burst_sum = {1'b0, burst_cnt} - {4'd0, base_tick} + (sel_edge ? mult : 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        burst_cnt <= 4'd0;
    else if (!ready_q) burst_cnt <= 4'd0;
    else               burst_cnt <= burst_sum[3:0];
  end

  wire       div1    = (scale_q == 3'd0) | (scale_q > 3'd5);
  wire [3:0] n_div   = {1'b0, scale_q} + 4'd2;
  wire [3:0] acc_sum = {1'b0, acc} + 4'd2;
  wire       pass    = div1 | (acc_sum >= n_div);
  wire [3:0] acc_sub = acc_sum - n_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc <= 3'd0;
    else if (!ready_q || div1) acc <= 3'd0;
    else if (base_tick)        acc <= pass ? acc_sub[2:0] : acc_sum[2:0];
  end

  assign clk_en  = ready_q & base_tick & pass;
  assign rd_data = addr ? {6'd0, err_q, ready_q} : {en_q, init_q, src_q, 1'b0, scale_q};

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) zero_wr |=> (!en_q && !init_q && !ready_q && !err_q)); // R1
  AST_INIT_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n) init_q |-> (en_q && wait_done)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_q && !zero_wr) |=> err_q); // R5
  AST_RDY_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n) ready_q |-> (init_q && en_q)); // R6
  AST_RDY_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready_q) |-> $past(init_q)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) ready_q |-> !burst_sum[4]); // R9
  AST_STROBE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n) clk_en |-> ready_q); // R11
endmodule

// File: tb/clkmul_seq_bench.sv
module clkmul_seq_bench;
  localparam int W = 20;
  localparam int L = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic int_ok = 1'b1, ext_ok = 1'b1, int_edge = 1'b0, ext_edge = 1'b0;
  logic clk_en;
  int checks = 0, failures = 0, strobes = 0;

  always #5 clk = ~clk;

  clkmul_seq #(.ENA_WAIT(W), .LOCK_CYCLES(L)) u_clkmul_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .int_ok(int_ok), .ext_ok(ext_ok),
    .int_edge(int_edge), .ext_edge(ext_edge), .clk_en(clk_en));

  always @(negedge clk) if (clk_en) strobes++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    addr = 1'b0; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic expect_reg(input logic a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    check(d == exp, req, d, exp);
  endtask

  function automatic logic [7:0] ctl(input bit en, input bit ini, input logic [1:0] s, input logic [2:0] c);
    return {en, ini, s, 1'b0, c};
  endfunction

  task automatic bring_up(input logic [1:0] s, input logic [2:0] c);
    wr(8'h00);
    wr(ctl(1, 0, s, c));
    idle(W);
    wr(ctl(1, 1, s, c));
    idle(L);
    expect_reg(1'b1, 8'h01, "R6 ready after bring-up");
  endtask

  task automatic pulse(input bit ext, input int n);
    for (int i = 0; i < n; i++) begin
      if (ext) ext_edge = 1'b1; else int_edge = 1'b1;
      @(negedge clk);
      ext_edge = 1'b0; int_edge = 1'b0;
      idle(5);
    end
  endtask

  task automatic t_reset;
    expect_reg(1'b0, 8'h00, "R1 control after reset");
    expect_reg(1'b1, 8'h00, "R1 status after reset");
    check(clk_en == 1'b0, "R11 no strobe after reset", clk_en, 0);
  endtask

  task automatic t_early_init;
    wr(8'h00);
    wr(ctl(1, 0, 2'b00, 3'd0));
    idle(W - 1);
    wr(ctl(1, 1, 2'b00, 3'd0));
    expect_reg(1'b1, 8'h02, "R3 early init refused, R5 error set");
    expect_reg(1'b0, 8'h80, "R3 init bit reads 0 after refusal");
    idle(2);
    wr(ctl(1, 1, 2'b00, 3'd0));
    expect_reg(1'b1, 8'h02, "R5 error sticky after good init");
    idle(L - 1);
    expect_reg(1'b1, 8'h02, "R6 ready still low one cycle before lock");
    idle(1);
    expect_reg(1'b1, 8'h03, "R6 ready after lock with sticky error");
    wr(8'h00);
    expect_reg(1'b0, 8'h00, "R1 zero write clears control");
    expect_reg(1'b1, 8'h00, "R1 zero write clears ready and error");
  endtask

  task automatic t_boundary;
    wr(8'h00);
    wr(ctl(1, 0, 2'b00, 3'd3));
    idle(W);
    wr(ctl(1, 1, 2'b00, 3'd3));
    expect_reg(1'b0, 8'hC3, "R2 readback layout, R3 init at exact wait");
    expect_reg(1'b1, 8'h00, "R3 no error at exact wait");
    idle(L);
    expect_reg(1'b1, 8'h01, "R6 ready at lock time");
  endtask

  task automatic t_sources;
    ext_ok = 1'b0;
    wr(8'h00); wr(ctl(1, 0, 2'b01, 3'd0)); idle(W); wr(ctl(1, 1, 2'b01, 3'd0));
    expect_reg(1'b1, 8'h02, "R4 ext source invalid refused");
    ext_ok = 1'b1;
    wr(ctl(1, 1, 2'b01, 3'd0));
    expect_reg(1'b0, 8'hD0, "R4 ext source valid accepted");
    wr(8'h00); wr(ctl(1, 0, 2'b11, 3'd0)); idle(W); wr(ctl(1, 1, 2'b11, 3'd0));
    expect_reg(1'b1, 8'h02, "R4 source 11 refused");
    int_ok = 1'b0;
    wr(8'h00); wr(ctl(1, 0, 2'b00, 3'd0)); idle(W); wr(ctl(1, 1, 2'b00, 3'd0));
    expect_reg(1'b1, 8'h02, "R4 internal source invalid refused");
    int_ok = 1'b1;
  endtask

  task automatic t_field_change;
    bring_up(2'b00, 3'd0);
    wr(ctl(1, 1, 2'b00, 3'd1));
    expect_reg(1'b1, 8'h00, "R7 scale change drops ready");
    idle(L);
    expect_reg(1'b1, 8'h01, "R7 ready after repeated init");
    wr(ctl(1, 0, 2'b01, 3'd1));
    expect_reg(1'b1, 8'h00, "R7 source change drops ready");
    expect_reg(1'b0, 8'h91, "R7 init bit cleared on change");
    wr(ctl(1, 1, 2'b01, 3'd1));
    idle(L);
    expect_reg(1'b1, 8'h01, "R7 re-init recovers ready");
    wr(ctl(1, 0, 2'b01, 3'd1));
    expect_reg(1'b1, 8'h00, "R8 init clear drops ready");
  endtask

  task automatic t_disable;
    bring_up(2'b00, 3'd0);
    wr(8'h03);
    expect_reg(1'b0, 8'h03, "R8 disable clears enable and init");
    expect_reg(1'b1, 8'h00, "R8 disable drops ready");
    wr(ctl(1, 0, 2'b00, 3'd3));
    idle(W - 1);
    wr(ctl(1, 1, 2'b00, 3'd3));
    expect_reg(1'b1, 8'h02, "R8 enable interval restarts after disable");
  endtask

  task automatic t_burst;
    bring_up(2'b00, 3'd0);
    strobes = 0; pulse(0, 1);
    check(strobes == 2, "R9 internal x2 burst", strobes, 2);
    strobes = 0; pulse(1, 1);
    check(strobes == 0, "R9 unselected edge ignored", strobes, 0);
    bring_up(2'b10, 3'd0);
    strobes = 0; pulse(1, 1);
    check(strobes == 4, "R9 external x4 burst", strobes, 4);
    strobes = 0; pulse(0, 1);
    check(strobes == 0, "R9 internal edge ignored on ext", strobes, 0);
    bring_up(2'b01, 3'd0);
    strobes = 0; pulse(1, 1);
    check(strobes == 2, "R9 external x2 burst", strobes, 2);
  endtask

  task automatic t_scaler;
    for (int c = 1; c <= 5; c++) begin
      bring_up(2'b00, 3'(c));
      strobes = 0; pulse(0, 3 * (c + 2));
      check(strobes == 12, $sformatf("R10 scale code %0d", c), strobes, 12);
    end
    bring_up(2'b10, 3'd2);
    strobes = 0; pulse(1, 4);
    check(strobes == 8, "R10 2/4 on x4 source", strobes, 8);
    bring_up(2'b00, 3'd6);
    strobes = 0; pulse(0, 5);
    check(strobes == 10, "R10 code 6 passes all", strobes, 10);
  endtask

  task automatic t_not_ready;
    wr(8'h00);
    wr(ctl(1, 0, 2'b00, 3'd0));
    strobes = 0; pulse(0, 3); pulse(1, 3);
    check(strobes == 0, "R11 no strobe while not ready", strobes, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_early_init();
    t_boundary();
    t_sources();
    t_field_change();
    t_disable();
    t_burst();
    t_scaler();
    t_not_ready();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule